// File: doc/BRIEF.md
# Serial Burst-Write Receiver with CRC Check

This block takes the data phase of a debug burst write. A command decoder has already decoded the burst and passes on its start address, its word count and its word size. The block then takes TDI bits one per shift strobe inside a single Shift-DR pass. Leading zeros are skipped until a 1 marks the start of the stream. Each complete word goes to a bus-side write port that holds its request until it is acknowledged. The block drives one TDO status bit per word and, after the host's 32-bit CRC, one match bit.

States: `ST_IDLE` is reached after reset and waits for a command. A command pulse moves any state to `ST_HUNT`, which skips bits until a 1 arrives. The 1 leads to `ST_DATA`, or to `ST_CRC` when the count is zero. `ST_DATA` leaves for `ST_STAT` on the last bit of a word. `ST_STAT` presents the status bit for one slot and then goes back to `ST_DATA`, or to `ST_CRC` once the count is used up. `ST_CRC` takes 32 bits and then moves to `ST_MATCH`. `ST_MATCH` presents the match bit for one slot and moves to `ST_DONE`. `ST_DONE` ignores everything until the next command.

Top module: `burst_write_deser`

## Requirements
- R1: After reset, tdo_o, wr_req_o and err_flag_o are 0 and no write is requested.
- R2: After a command pulse, shifted 0 bits are ignored. The first 1 bit is consumed as a start marker, and the bit after it is bit 0 of the first word.
- R3: Words arrive LSB first. The size code sets the word length: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. wr_data_o carries the word zero-extended in its low bits. wr_size_o carries the code with 3 reported as 2.
- R4: The shift slot right after a word's last bit is a status slot. Its TDI bit is ignored, and tdo_o shows 1 when that word was issued to the write port.
- R5: If a request is still outstanding when a word completes, the status bit is 0. The word is dropped, and the outstanding request keeps its address and data.
- R6: The first issued write uses the command address. Each issued write advances the next address by 1, 2 or 4 bytes for codes 0, 1 and 2/3. A dropped word does not advance it.
- R7: wr_req_o stays high with a stable address and data until wr_ack_i or wr_err_i is sampled high, and falls in the next cycle.
- R8: After the last word (or right after the start marker for a count of zero), 32 CRC bits are taken LSB first. The slot after them shows tdo_o = 1 when they equal the computed CRC.
- R9: The match bit is 0 when the received CRC differs from the computed one in any bit.
- R10: wr_err_i sampled high during a request sets err_flag_o, which stays set. err_addr_o holds the address of the first failing write.
- R11: Once the match slot has passed, further shifted bits cause no write and tdo_o stays 0 until the next command.
- R12: The CRC is initialised to all ones at each command. For every data bit d, including bits of dropped words, it updates as crc = (crc >> 1) XOR (0xEDB88320 if d XOR crc[0] else 0). It is compared without inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock (TCK domain) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_go_i | input | 1 | One-cycle pulse that arms a new burst |
| cmd_addr_i | input | AW | Start address of the burst |
| cmd_len_i | input | LW | Number of words in the burst |
| cmd_size_i | input | 2 | Word size code |
| shift_i | input | 1 | Shift-DR strobe, one bit per cycle when high |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Status and match bits out |
| wr_req_o | output | 1 | Write request, held until acknowledged |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | 32 | Write data, zero-extended |
| wr_size_o | output | 2 | Normalised size code of the write |
| wr_ack_i | input | 1 | Write completed |
| wr_err_i | input | 1 | Write completed with a bus error |
| err_flag_o | output | 1 | Sticky bus-error flag |
| err_addr_o | output | AW | Address of the first failing write |

## Verification
A bit counter or state that is off by one shows up within one word. The status slot moves, so tdo_o reads 0 where the host expects 1, or the word lands on the bus shifted by a bit. A fault in the CRC register or in the comparison shows only at the match slot, 32 shifts after the last word. A wrong address step or wrong drop handling shows on the first following request at wr_addr_o and wr_data_o. Error-capture faults show at err_flag_o in the cycle after the failing response.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_DATA,
        ST_STAT,
        ST_CRC,
        ST_MATCH,
        ST_DONE
    } bwd_state_e;

    // normalised size code: 3 behaves as 2 (32-bit)
    function automatic logic [1:0] bwd_norm(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    function automatic logic [5:0] bwd_bits(input logic [1:0] code);
        logic [1:0] n;
        n = bwd_norm(code);
        case (n)
            2'd0:    return 6'd8;
            2'd1:    return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/bwd_crc_serial.sv
module bwd_crc_serial #(
    parameter int          CW   = 32,
    parameter logic [CW-1:0] POLY = 32'hEDB88320
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          en_i,
    input  logic          bit_i,
    output logic [CW-1:0] crc_o
);
    logic [CW-1:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (init_i) begin
            crc_q <= '1;
        end else if (en_i) begin
            crc_q <= (crc_q >> 1) ^ ({CW{bit_i ^ crc_q[0]}} & POLY);
        end
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/bwd_wr_port.sv
module bwd_wr_port
    import bwd_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic [1:0]    size_i,
    input  logic          issue_i,
    input  logic [DW-1:0] data_i,
    output logic          busy_o,
    output logic          wr_req_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic [1:0]    wr_size_o,
    input  logic          wr_ack_i,
    input  logic          wr_err_i,
    output logic          err_flag_o,
    output logic [AW-1:0] err_addr_o
);
    logic [AW-1:0] next_q, addr_q, eaddr_q;
    logic [DW-1:0] data_q;
    logic [1:0]    size_q;
    logic          req_q, flag_q;
    logic [AW-1:0] step;

    assign step = AW'(3'd1 << size_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_q  <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            size_q  <= 2'd0;
            req_q   <= 1'b0;
            flag_q  <= 1'b0;
            eaddr_q <= '0;
        end else begin
            if (load_i) begin
                next_q <= base_i;
                size_q <= bwd_norm(size_i);
            end else if (issue_i && !req_q) begin
                req_q  <= 1'b1;
                addr_q <= next_q;
                data_q <= data_i;
                next_q <= next_q + step;
            end
            if (req_q && (wr_ack_i || wr_err_i)) begin
                req_q <= 1'b0;
            end
            if (req_q && wr_err_i && !flag_q) begin
                flag_q  <= 1'b1;
                eaddr_q <= addr_q;
            end
        end
    end

    assign busy_o     = req_q;
    assign wr_req_o   = req_q;
    assign wr_addr_o  = addr_q;
    assign wr_data_o  = data_q;
    assign wr_size_o  = size_q;
    assign err_flag_o = flag_q;
    assign err_addr_o = eaddr_q;
endmodule

// File: rtl/burst_write_deser.sv
module burst_write_deser
    import bwd_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          LW       = 16,
    parameter logic [31:0] CRC_POLY = 32'hEDB88320
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_go_i,
    input  logic [AW-1:0] cmd_addr_i,
    input  logic [LW-1:0] cmd_len_i,
    input  logic [1:0]    cmd_size_i,
    input  logic          shift_i,
    input  logic          tdi_i,
    output logic          tdo_o,
    output logic          wr_req_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [31:0]   wr_data_o,
    output logic [1:0]    wr_size_o,
    input  logic          wr_ack_i,
    input  logic          wr_err_i,
    output logic          err_flag_o,
    output logic [AW-1:0] err_addr_o
);
    localparam int WMAX = 32;
    localparam int CW   = 32;
    localparam int BCW  = $clog2(WMAX) + 1;

    bwd_state_e     state_q, state_d;
    logic [BCW-1:0] bitcnt_q, nbits_q;
    logic [LW-1:0]  left_q;
    logic [WMAX-1:0] sh_q, sh_in, word_val;
    logic [CW-1:0]  rx_q, rx_in, crc_val;
    logic           stat_q, match_q;
    logic           last_bit, crc_end, issue, busy;

    assign sh_in    = {tdi_i, sh_q[WMAX-1:1]};
    assign rx_in    = {tdi_i, rx_q[CW-1:1]};
    assign word_val = sh_in >> (BCW'(WMAX) - nbits_q);
    assign last_bit = (bitcnt_q == nbits_q - BCW'(1));
    assign crc_end  = (bitcnt_q == BCW'(CW - 1));
    assign issue    = !cmd_go_i && shift_i && (state_q == ST_DATA) && last_bit;

    bwd_crc_serial #(.CW(CW), .POLY(CRC_POLY)) crc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (cmd_go_i),
        .en_i   (!cmd_go_i && shift_i && (state_q == ST_DATA)),
        .bit_i  (tdi_i),
        .crc_o  (crc_val)
    );

    bwd_wr_port #(.AW(AW), .DW(WMAX)) port_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cmd_go_i),
        .base_i     (cmd_addr_i),
        .size_i     (cmd_size_i),
        .issue_i    (issue),
        .data_i     (word_val),
        .busy_o     (busy),
        .wr_req_o   (wr_req_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .wr_size_o  (wr_size_o),
        .wr_ack_i   (wr_ack_i),
        .wr_err_i   (wr_err_i),
        .err_flag_o (err_flag_o),
        .err_addr_o (err_addr_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cmd_go_i) begin
            state_d = ST_HUNT;
        end else if (shift_i) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_HUNT:  if (tdi_i) state_d = (left_q == '0) ? ST_CRC : ST_DATA;
                ST_DATA:  if (last_bit) state_d = ST_STAT;
                ST_STAT:  state_d = (left_q == '0) ? ST_CRC : ST_DATA;
                ST_CRC:   if (crc_end) state_d = ST_MATCH;
                ST_MATCH: state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            nbits_q  <= BCW'(WMAX);
            left_q   <= '0;
            sh_q     <= '0;
            rx_q     <= '0;
            stat_q   <= 1'b0;
            match_q  <= 1'b0;
        end else if (cmd_go_i) begin
            bitcnt_q <= '0;
            nbits_q  <= bwd_bits(cmd_size_i);
            left_q   <= cmd_len_i;
            stat_q   <= 1'b0;
            match_q  <= 1'b0;
        end else if (shift_i) begin
            case (state_q)
                ST_DATA: begin
                    sh_q <= sh_in;
                    if (last_bit) begin
                        bitcnt_q <= '0;
                        left_q   <= left_q - LW'(1);
                        stat_q   <= !busy;
                    end else begin
                        bitcnt_q <= bitcnt_q + BCW'(1);
                    end
                end
                ST_CRC: begin
                    rx_q <= rx_in;
                    if (crc_end) begin
                        bitcnt_q <= '0;
                        match_q  <= (rx_in == crc_val);
                    end else begin
                        bitcnt_q <= bitcnt_q + BCW'(1);
                    end
                end
                default: bitcnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_STAT:  tdo_o = stat_q;
            ST_MATCH: tdo_o = match_q;
            default:  tdo_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/burst_write_deser_chk.sv
module burst_write_deser_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_req_o,
    input logic [AW-1:0] wr_addr_o,
    input logic [31:0]   wr_data_o,
    input logic          wr_ack_i,
    input logic          wr_err_i,
    input logic          err_flag_o,
    input logic [AW-1:0] err_addr_o
);
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ack_i && !wr_err_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

    a_r7_req_release: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && (wr_ack_i || wr_err_i) |=> !wr_req_o);

    a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && wr_err_i |=> err_flag_o);

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag_o |=> err_flag_o && $stable(err_addr_o));
endmodule

bind burst_write_deser burst_write_deser_chk #(.AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req_o   (wr_req_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .wr_ack_i   (wr_ack_i),
    .wr_err_i   (wr_err_i),
    .err_flag_o (err_flag_o),
    .err_addr_o (err_addr_o)
);

// File: tb/burst_write_deser_tb_top.sv
module burst_write_deser_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LW = 16;

    typedef struct packed {
        logic [1:0]  sz;
        logic [2:0]  len;
        logic [31:0] addr;
        logic [3:0]  lead;
        logic        bad;
        logic [31:0] w0, w1, w2, w3;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{2'd2, 3'd1, 32'h0000_1000, 4'd0, 1'b0, 32'hDEADBEEF, 32'h0, 32'h0, 32'h0},
        '{2'd0, 3'd4, 32'h0000_0040, 4'd3, 1'b0, 32'h0000_00A5, 32'h0000_003C, 32'h0000_00FF, 32'h0000_0001},
        '{2'd1, 3'd3, 32'h0000_0100, 4'd5, 1'b0, 32'h0000_1234, 32'h0000_ABCD, 32'h0000_8001, 32'h0},
        '{2'd2, 3'd2, 32'h8000_0000, 4'd1, 1'b1, 32'h0123_4567, 32'h89AB_CDEF, 32'h0, 32'h0},
        '{2'd3, 3'd1, 32'h0000_0010, 4'd0, 1'b0, 32'hCAFE_F00D, 32'h0, 32'h0, 32'h0},
        '{2'd0, 3'd0, 32'h0000_0000, 4'd2, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_go_i = 1'b0;
    logic [AW-1:0] cmd_addr_i = '0;
    logic [LW-1:0] cmd_len_i = '0;
    logic [1:0]    cmd_size_i = '0;
    logic          shift_i = 1'b0;
    logic          tdi_i = 1'b0;
    logic          tdo_o;
    logic          wr_req_o;
    logic [AW-1:0] wr_addr_o;
    logic [31:0]   wr_data_o;
    logic [1:0]    wr_size_o;
    logic          wr_ack_i = 1'b0;
    logic          wr_err_i = 1'b0;
    logic          err_flag_o;
    logic [AW-1:0] err_addr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bus responder state (written only by the responder, except the controls)
    int          ack_delay = 0;
    int          err_at = -1;
    int          wr_cnt = 0;
    logic [31:0] log_addr [32];
    logic [31:0] log_data [32];
    logic [1:0]  log_size [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_write_deser #(.AW(AW), .LW(LW)) dut_i (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [31:0] d, input int n);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < n; i++)
            r = (r >> 1) ^ ((d[i] ^ r[0]) ? 32'hEDB88320 : 32'h0);
        return r;
    endfunction

    function automatic logic [31:0] pick(input vec_t v, input int i);
        case (i)
            0: return v.w0;
            1: return v.w1;
            2: return v.w2;
            default: return v.w3;
        endcase
    endfunction

    task automatic shift_bit(input logic b, output logic o);
        @(negedge clk);
        o = tdo_o;
        tdi_i = b;
        shift_i = 1'b1;
        @(posedge clk);
        #1 shift_i = 1'b0;
    endtask

    task automatic send_cmd(input logic [31:0] a, input int len, input logic [1:0] sz);
        @(negedge clk);
        cmd_go_i = 1'b1;
        cmd_addr_i = a;
        cmd_len_i = LW'(len);
        cmd_size_i = sz;
        @(posedge clk);
        #1 cmd_go_i = 1'b0;
    endtask

    // write port responder
    initial begin
        int wait_cnt;
        wait_cnt = 0;
        forever begin
            @(negedge clk);
            wr_ack_i = 1'b0;
            wr_err_i = 1'b0;
            if (wr_req_o) begin
                if (wait_cnt >= ack_delay) begin
                    if (wr_cnt == err_at) wr_err_i = 1'b1;
                    else                  wr_ack_i = 1'b1;
                    log_addr[wr_cnt % 32] = wr_addr_o;
                    log_data[wr_cnt % 32] = wr_data_o;
                    log_size[wr_cnt % 32] = wr_size_o;
                    wr_cnt++;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic o;
        logic [31:0] crc;
        logic [31:0] w;
        int nb, nbytes, base;

        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(tdo_o == 1'b0, "R1 tdo", 64'(tdo_o), 0);
        chk(wr_req_o == 1'b0, "R1 req", 64'(wr_req_o), 0);
        chk(err_flag_o == 1'b0, "R1 flag", 64'(err_flag_o), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // table-driven bursts: R2 R3 R4 R6 R8 R9 R11 R12
        for (int e = 0; e < NV; e++) begin
            nb     = (TBL[e].sz == 2'd0) ? 8 : (TBL[e].sz == 2'd1) ? 16 : 32;
            nbytes = nb / 8;
            base   = wr_cnt;
            ack_delay = 0;
            err_at = -1;
            send_cmd(TBL[e].addr, int'(TBL[e].len), TBL[e].sz);
            for (int z = 0; z < int'(TBL[e].lead); z++) shift_bit(1'b0, o);
            shift_bit(1'b1, o);
            crc = 32'hFFFF_FFFF;
            for (int k = 0; k < int'(TBL[e].len); k++) begin
                w = pick(TBL[e], k);
                for (int b = 0; b < nb; b++) shift_bit(w[b], o);
                crc = crc_upd(crc, w, nb);
                shift_bit(1'b1, o);
                chk(o == 1'b1, "R4 status", 64'(o), 1);
            end
            if (TBL[e].bad) crc = crc ^ 32'h0000_0100;
            for (int b = 0; b < 32; b++) shift_bit(crc[b], o);
            shift_bit(1'b0, o);
            if (TBL[e].bad) chk(o == 1'b0, "R9 match", 64'(o), 0);
            else            chk(o == 1'b1, "R8 R12 match", 64'(o), 1);
            for (int x = 0; x < 4; x++) begin
                shift_bit(1'b1, o);
                chk(o == 1'b0, "R11 tdo after match", 64'(o), 0);
            end
            repeat (4) @(posedge clk);
            #1;
            chk(wr_cnt - base == int'(TBL[e].len), "R11 R2 write count", 64'(wr_cnt - base), 64'(TBL[e].len));
            for (int k = 0; k < int'(TBL[e].len); k++) begin
                w = pick(TBL[e], k);
                if (nb < 32) w = w & ((32'h1 << nb) - 32'h1);
                chk(log_data[(base + k) % 32] == w, "R3 data", 64'(log_data[(base + k) % 32]), 64'(w));
                chk(log_addr[(base + k) % 32] == TBL[e].addr + 32'(k * nbytes), "R6 addr",
                    64'(log_addr[(base + k) % 32]), 64'(TBL[e].addr + 32'(k * nbytes)));
                chk(log_size[(base + k) % 32] == ((TBL[e].sz == 2'd3) ? 2'd2 : TBL[e].sz), "R3 size",
                    64'(log_size[(base + k) % 32]), 64'(TBL[e].sz));
            end
        end

        // R5: outstanding write makes the next word drop
        ack_delay = 1000000;
        base = wr_cnt;
        send_cmd(32'h300, 2, 2'd0);
        shift_bit(1'b1, o);
        crc = 32'hFFFF_FFFF;
        w = 32'h11;
        for (int b = 0; b < 8; b++) shift_bit(w[b], o);
        crc = crc_upd(crc, w, 8);
        shift_bit(1'b0, o);
        chk(o == 1'b1, "R4 first status", 64'(o), 1);
        w = 32'h22;
        for (int b = 0; b < 8; b++) shift_bit(w[b], o);
        crc = crc_upd(crc, w, 8);
        shift_bit(1'b0, o);
        chk(o == 1'b0, "R5 busy status", 64'(o), 0);
        chk(wr_req_o && wr_data_o == 32'h11, "R5 R7 pending kept", 64'(wr_data_o), 64'h11);
        chk(wr_addr_o == 32'h300, "R5 addr kept", 64'(wr_addr_o), 64'h300);
        for (int b = 0; b < 32; b++) shift_bit(crc[b], o);
        shift_bit(1'b0, o);
        chk(o == 1'b1, "R12 crc covers dropped word", 64'(o), 1);
        ack_delay = 0;
        repeat (5) @(posedge clk);
        #1;
        chk(wr_cnt - base == 1, "R5 one write", 64'(wr_cnt - base), 1);
        chk(log_data[base % 32] == 32'h11, "R5 data", 64'(log_data[base % 32]), 64'h11);

        // R10: bus error on second write
        base = wr_cnt;
        err_at = base + 1;
        send_cmd(32'h2000, 3, 2'd2);
        shift_bit(1'b1, o);
        crc = 32'hFFFF_FFFF;
        for (int k = 0; k < 3; k++) begin
            w = 32'hA000_0000 + 32'(k);
            for (int b = 0; b < 32; b++) shift_bit(w[b], o);
            crc = crc_upd(crc, w, 32);
            shift_bit(1'b0, o);
        end
        for (int b = 0; b < 32; b++) shift_bit(crc[b], o);
        shift_bit(1'b0, o);
        repeat (4) @(posedge clk);
        #1;
        chk(err_flag_o == 1'b1, "R10 flag", 64'(err_flag_o), 1);
        chk(err_addr_o == 32'h2004, "R10 addr", 64'(err_addr_o), 64'h2004);
        chk(log_addr[(base + 2) % 32] == 32'h2008, "R6 advance after error",
            64'(log_addr[(base + 2) % 32]), 64'h2008);

        // R10: later error keeps the first address
        base = wr_cnt;
        err_at = base;
        send_cmd(32'h5000, 1, 2'd2);
        shift_bit(1'b1, o);
        for (int b = 0; b < 32; b++) shift_bit(1'b0, o);
        shift_bit(1'b0, o);
        repeat (4) @(posedge clk);
        #1;
        chk(err_flag_o == 1'b1, "R10 flag sticky", 64'(err_flag_o), 1);
        chk(err_addr_o == 32'h2004, "R10 first addr kept", 64'(err_addr_o), 64'h2004);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule